// File: doc/BRIEF.md
# Raise-once message interrupt generator

This block lives inside a peripheral, for example a packet receiver, and converts internal event pulses into message-signalled interrupt requests. A one-bit raised marker coalesces a burst of events into one interrupt: the first event while the marker is clear raises an interrupt and sets the marker. Later events are then absorbed until software pulses a clear strobe or the receive queue reports empty. Each raise leaves through a valid/ready message port as one memory-write request that carries a fixed address and data word.

A mask bit, which resets to masked, defers delivery. A raise that arrives while masked, or while the port is still busy with an earlier message, is recorded in a pending bit. When the mask is clear and the port is idle, one message is sent for the pending request and the pending bit clears. A request is therefore delayed by masking but never dropped.

The message port is a two-state machine. In ST_IDLE no request is offered. The "issue" transition, ST_IDLE to ST_SEND, is taken when the mask is clear and either a raise arrives or pending is set. In ST_SEND the request is held. The "retire" transition, ST_SEND to ST_IDLE, is taken on the cycle ready is high.

Top module: `msi_raise_gen`

## Requirements
- R1: After reset, the marker (raised_o) is 0, pending (pend_o) is 0, msg_valid_o is 0 and the mask (mask_o) is 1.
- R2: An event (evt_i high for a cycle) while the marker is clear raises an interrupt: raised_o is 1 from the next cycle.
- R3: While the marker is set and no clear is applied, events raise nothing. A burst of any length gives exactly one message, and the marker stays set.
- R4: A cycle with sw_clr_i high or q_empty_i high, and no event, clears the marker from the next cycle.
- R5: An unmasked raise with the port idle and nothing pending makes msg_valid_o high in the next cycle, with msg_addr_o = MSG_ADDR and msg_data_o = MSG_DATA. Exactly one message is transferred, on the first cycle msg_valid_o and msg_ready_i are both high.
- R6: While msg_valid_o is high and msg_ready_i is low, msg_valid_o, msg_addr_o and msg_data_o hold.
- R7: mask_we_i loads mask_d_i into the mask on the next edge, where 1 means masked. A raise while masked sends no message and sets pend_o. Pending is kept for as long as the mask stays set.
- R8: When the mask clears while pending is set and the port is idle, msg_valid_o rises one cycle after the mask clears, pend_o clears at the same time, and one message is sent.
- R9: An event in the same cycle as a clear (sw_clr_i or q_empty_i) counts as arriving after the clear, so it raises a fresh interrupt.
- R10: A raise while a message is outstanding is recorded as pending. It is sent as a second message after the first retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Internal event pulse |
| q_empty_i | input | 1 | Receive queue is empty (clears marker) |
| sw_clr_i | input | 1 | Software clear strobe for the marker |
| mask_we_i | input | 1 | Mask write strobe |
| mask_d_i | input | 1 | Mask write value, 1 = masked |
| msg_ready_i | input | 1 | Message port ready |
| msg_valid_o | output | 1 | Message request valid |
| msg_addr_o | output | ADDR_W | Message write address |
| msg_data_o | output | DATA_W | Message write data |
| mask_o | output | 1 | Current mask bit |
| pend_o | output | 1 | Current pending bit |
| raised_o | output | 1 | Raised marker |

## Verification
Two situations are hard to reach from the ports: a second raise landing while the first message is still unaccepted, and a pending request that must survive masking and then go out exactly once. The stimulus holds ready low, clears the marker and fires a new event during ST_SEND, which forces the merge into pending. Separately, it raises while masked and then unmasks, counting transfers. A sweep over burst length and ready delay checks that every combination gives a single message.

// File: rtl/msi_raise_pkg.sv
package msi_raise_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } port_state_t;
endpackage

// File: rtl/raise_marker.sv
module raise_marker (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic raise_o,
    output logic marker_o
);
    logic marker_q;

    // clear is applied first, so an event in a clear cycle still raises
    always_comb begin
        raise_o = evt_i & (~marker_q | clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            marker_q <= 1'b0;
        end else if (raise_o) begin
            marker_q <= 1'b1;
        end else if (clr_i) begin
            marker_q <= 1'b0;
        end
    end

    assign marker_o = marker_q;

    // R3: marker sticks until a clear arrives
    a_r3_marker_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (marker_o && !clr_i) |=> marker_o);
endmodule

// File: rtl/mask_pend.sv
module mask_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic mask_we_i,
    input  logic mask_d_i,
    input  logic raise_i,
    input  logic take_i,
    output logic mask_o,
    output logic pend_o
);
    logic mask_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
        end else if (mask_we_i) begin
            mask_q <= mask_d_i;
        end
    end

    // a raise in the cycle a message is taken merges with that message
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (take_i) begin
            pend_q <= 1'b0;
        end else if (raise_i) begin
            pend_q <= 1'b1;
        end
    end

    assign mask_o = mask_q;
    assign pend_o = pend_q;

    // R7: a pending request is never lost while masked
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && mask_o) |=> pend_o);
endmodule

// File: rtl/msg_port_fsm.sv
module msg_port_fsm #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] MSG_ADDR = '0,
    parameter logic [DATA_W-1:0] MSG_DATA = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_i,
    input  logic              mask_i,
    input  logic              pend_i,
    input  logic              ready_i,
    output logic              take_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    import msi_raise_pkg::*;

    port_state_t state_q;
    port_state_t state_d;

    always_comb begin
        state_d = state_q;
        take_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!mask_i && (raise_i || pend_i)) begin
                    take_o  = 1'b1;
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (ready_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        valid_o = (state_q == ST_SEND);
        addr_o  = valid_o ? MSG_ADDR : '0;
        data_o  = valid_o ? MSG_DATA : '0;
    end

    // R6: request held until accepted
    a_r6_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
    // R7: no message starts from a masked cycle
    a_r7_no_send_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> !$past(mask_i));
    // R8: pending is consumed when a message starts
    a_r8_pend_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> !pend_i);
endmodule

// File: rtl/msi_raise_gen.sv
module msi_raise_gen #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] MSG_ADDR = 32'hFEE0_1000,
    parameter logic [DATA_W-1:0] MSG_DATA = 32'h0000_0041
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_i,
    input  logic              q_empty_i,
    input  logic              sw_clr_i,
    input  logic              mask_we_i,
    input  logic              mask_d_i,
    input  logic              msg_ready_i,
    output logic              msg_valid_o,
    output logic [ADDR_W-1:0] msg_addr_o,
    output logic [DATA_W-1:0] msg_data_o,
    output logic              mask_o,
    output logic              pend_o,
    output logic              raised_o
);
    logic clr_any;
    logic raise;
    logic take;

    assign clr_any = sw_clr_i | q_empty_i;

    raise_marker u_marker (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_any),
        .raise_o  (raise),
        .marker_o (raised_o)
    );

    mask_pend u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we_i (mask_we_i),
        .mask_d_i  (mask_d_i),
        .raise_i   (raise),
        .take_i    (take),
        .mask_o    (mask_o),
        .pend_o    (pend_o)
    );

    msg_port_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MSG_ADDR (MSG_ADDR),
        .MSG_DATA (MSG_DATA)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (raise),
        .mask_i  (mask_o),
        .pend_i  (pend_o),
        .ready_i (msg_ready_i),
        .take_o  (take),
        .valid_o (msg_valid_o),
        .addr_o  (msg_addr_o),
        .data_o  (msg_data_o)
    );

    // R5: unmasked raise on idle port with nothing pending issues next cycle
    a_r5_prompt_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (raise && !mask_o && !pend_o && !msg_valid_o) |=> msg_valid_o);
    // R2: a raise sets the marker
    a_r2_marker_set: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && (!raised_o || clr_any)) |=> raised_o);
endmodule

// File: tb/sim_msi_raise_gen.sv
module sim_msi_raise_gen;
    localparam logic [31:0] EA = 32'hFEE0_1000;
    localparam logic [31:0] ED = 32'h0000_0041;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt = 0, qe = 0, clr = 0, mwe = 0, md = 0, rdy = 0;
    logic vld, msk, pnd, rsd;
    logic [31:0] addr, data;
    int total = 0;
    int bad = 0;
    int msgs = 0;
    bit done = 0;

    always #5 clk = ~clk;

    msi_raise_gen u0 (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .q_empty_i(qe), .sw_clr_i(clr),
        .mask_we_i(mwe), .mask_d_i(md), .msg_ready_i(rdy),
        .msg_valid_o(vld), .msg_addr_o(addr), .msg_data_o(data),
        .mask_o(msk), .pend_o(pnd), .raised_o(rsd)
    );

    always @(posedge clk) if (rst_n && vld && rdy) msgs = msgs + 1;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drain();
        rdy = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        rdy = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    initial begin
        int base;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rsd == 0, "R1 raised", rsd, 0);
        chk(pnd == 0, "R1 pend", pnd, 0);
        chk(vld == 0, "R1 valid", vld, 0);
        chk(msk == 1, "R1 mask", msk, 1);

        mwe = 1; md = 0; tick(); mwe = 0;
        chk(msk == 0, "R7 mask write", msk, 0);

        // R2 / R5 / R6
        base = msgs;
        evt = 1; tick(); evt = 0;
        chk(rsd == 1, "R2 raised", rsd, 1);
        chk(vld == 1, "R5 valid next cycle", vld, 1);
        chk(addr == EA, "R5 addr", int'(addr), int'(EA));
        chk(data == ED, "R5 data", int'(data), int'(ED));
        for (int i = 0; i < 3; i++) begin
            tick();
            chk(vld == 1 && addr == EA, "R6 hold", vld, 1);
        end
        rdy = 1; tick(); rdy = 0;
        chk(vld == 0, "R5 retire", vld, 0);
        chk(msgs == base + 1, "R5 one message", msgs - base, 1);

        // R3 sweep: burst length x ready delay
        for (int n = 1; n <= 6; n++) begin
            for (int d = 0; d < 4; d++) begin
                pulse_clr();
                chk(rsd == 0, "R4 sw clear", rsd, 1'b0);
                base = msgs;
                for (int k = 0; k < n; k++) begin
                    evt = 1; if (k == d) rdy = 1; tick();
                end
                evt = 0;
                drain();
                evt = 1; tick(); evt = 0; drain();
                chk(msgs == base + 1, "R3 burst one message", msgs - base, 1);
                chk(rsd == 1, "R3 marker held", rsd, 1);
            end
        end

        // R4 queue empty clears
        qe = 1; tick(); qe = 0;
        chk(rsd == 0, "R4 queue empty clear", rsd, 0);
        base = msgs;
        evt = 1; tick(); evt = 0; drain();
        chk(msgs == base + 1, "R4 raise after empty", msgs - base, 1);

        // R9 event with clear in same cycle, both clear sources
        for (int s = 0; s < 2; s++) begin
            base = msgs;
            chk(rsd == 1, "R9 marker set before", rsd, 1);
            evt = 1; if (s == 0) clr = 1; else qe = 1;
            tick();
            evt = 0; clr = 0; qe = 0;
            chk(rsd == 1 && vld == 1, "R9 fresh raise", vld, 1);
            drain();
            chk(msgs == base + 1, "R9 one message", msgs - base, 1);
        end

        // R7 masked raise goes to pending
        mwe = 1; md = 1; tick(); mwe = 0;
        pulse_clr();
        base = msgs;
        evt = 1; tick(); evt = 0;
        chk(vld == 0, "R7 masked no valid", vld, 0);
        chk(pnd == 1, "R7 pending set", pnd, 1);
        rdy = 1;
        for (int i = 0; i < 5; i++) tick();
        chk(msgs == base, "R7 no message while masked", msgs - base, 0);
        chk(pnd == 1, "R7 pending kept", pnd, 1);
        rdy = 0;
        // R8 unmask releases exactly one
        mwe = 1; md = 0; tick(); mwe = 0;
        chk(vld == 0, "R8 not yet", vld, 0);
        tick();
        chk(vld == 1, "R8 valid after unmask", vld, 1);
        chk(pnd == 0, "R8 pending cleared", pnd, 0);
        drain();
        chk(msgs == base + 1, "R8 one message", msgs - base, 1);

        // R10 raise during outstanding message
        pulse_clr();
        base = msgs;
        evt = 1; tick(); evt = 0;
        chk(vld == 1, "R10 first valid", vld, 1);
        pulse_clr();
        evt = 1; tick(); evt = 0;
        chk(pnd == 1, "R10 pending during send", pnd, 1);
        rdy = 1; tick(); rdy = 0;
        chk(msgs == base + 1, "R10 first done", msgs - base, 1);
        tick();
        chk(vld == 1 && pnd == 0, "R10 second issued", vld, 1);
        drain();
        chk(msgs == base + 2, "R10 two messages", msgs - base, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule